// File: doc/BRIEF.md
# Programmable Digital Glitch Filter

This block cleans up to 32 digital input pins with one shared glitch-rejection setting. Each pin has its own enable bit. While a pin is enabled, its filter absorbs any excursion that lasts no more than a programmed number of filter ticks. A level that stays different from the current output for longer than that appears on the output. While a pin is disabled, its output is held at 0.

The filter tick comes from one of two sources. It is either every cycle of the block clock, or a slow low-power tick (nominally 1 kHz) that is delivered as a one-cycle enable pulse in the block clock domain. The tick source and the width setting are shared by all pins. They can be changed only while every pin is disabled.

Software reaches three configuration registers through a small synchronous write port with a combinational read-back. The registers are the per-pin enable mask, the tick-source select and the width.

Top module: `pin_deglitch`

## Requirements
- R1: After reset, the enable mask, tick-source select and width all read 0, and every `pin_out` bit is 0.
- R2: A write with `cfg_sel`=0 loads the enable mask (bit i enables pin i). `cfg_sel`=1 loads the tick source from `cfg_wdata[0]`. `cfg_sel`=2 loads the width from `cfg_wdata[4:0]`. A read returns the addressed register zero-extended to 32 bits, and `cfg_sel`=3 reads 0.
- R3: A pin whose enable bit is 0 drives 0 on `pin_out` and clears its count. The output is 0 from the second clock edge after the disabling write.
- R4: With width 0, an enabled pin's output takes the input value at the first filter tick after the input changes.
- R5: With width W, an input excursion that lasts W or fewer consecutive filter ticks leaves the output unchanged.
- R6: With width W, an input held different from the output for W+1 consecutive filter ticks reaches the output at the clock edge of the (W+1)th tick.
- R7: A tick-source value of 0 makes every clock a filter tick. A value of 1 makes only cycles with `slow_tick`=1 filter ticks, and outputs hold between ticks.
- R8: Writes to the tick-source or width register are ignored while any enable bit is 1.
- R9: Each pin is filtered independently: activity on one pin never changes another pin's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (bus clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse of the slow low-power tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 enable, 1 tick source, 2 width, 3 unused |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| pin_in | input | 32 | Raw pin levels, synchronous to clk |
| pin_out | output | 32 | Filtered pin levels |

## Verification
The assertions take for granted that `pin_in` and `slow_tick` are synchronous to `clk` and stable around its rising edge. They also take for granted that the width and tick source change only while the mask is all zero, which the block enforces itself. The stimulus drives every input on the falling edge. It reconfigures only after clearing the mask, except for deliberate writes made while pins are enabled, which must be dropped. Pin activity is generated with sparse random toggles so that both short glitches and long stable levels occur under both tick sources and several widths.

// File: rtl/dgl_pkg.sv
package dgl_pkg;
  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_TICKSRC = 2'd1,
    CFG_WIDTH  = 2'd2,
    CFG_SPARE  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/dgl_regs.sv
module dgl_regs
  import dgl_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int CNT_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NPINS-1:0]  en_q,
  output logic              slow_sel_q,
  output logic [CNT_W-1:0]  width_q
);
  cfg_sel_e           sel_e;
  logic               cfg_open;
  logic [NPINS-1:0]   en_d;
  logic               slow_sel_d;
  logic [CNT_W-1:0]   width_d;

  assign sel_e    = cfg_sel_e'(sel);
  assign cfg_open = (en_q == '0);

  always_comb begin
    en_d       = en_q;
    slow_sel_d = slow_sel_q;
    width_d    = width_q;
    if (we) begin
      unique case (sel_e)
        CFG_ENABLE:  en_d = wdata[NPINS-1:0];
        CFG_TICKSRC: if (cfg_open) slow_sel_d = wdata[0];
        CFG_WIDTH:   if (cfg_open) width_d = wdata[CNT_W-1:0];
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      slow_sel_q <= 1'b0;
      width_q    <= '0;
    end else begin
      en_q       <= en_d;
      slow_sel_q <= slow_sel_d;
      width_q    <= width_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel_e)
      CFG_ENABLE:  rdata = DATA_W'(en_q);
      CFG_TICKSRC: rdata = DATA_W'(slow_sel_q);
      CFG_WIDTH:   rdata = DATA_W'(width_q);
      default:     rdata = '0;
    endcase
  end

  // R2: enable mask takes the written value
  p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 2'd0) |=> (en_q == $past(wdata[NPINS-1:0])));

  // R8: shared settings frozen while any pin is enabled
  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != '0) |=> ($stable(width_q) && $stable(slow_sel_q)));
endmodule

// File: rtl/dgl_cell.sv
module dgl_cell #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             din,
  input  logic [CNT_W-1:0] width,
  output logic             dout
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             differs;

  assign differs = (din != out_q);

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (!en) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (tick) begin
      if (!differs) begin
        cnt_d = '0;
      end else if (cnt_q >= width) begin
        out_d = din;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign dout = out_q;

  // R3: disabled pin is forced low
  p_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !dout);

  // R7: no filter tick means the output holds
  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(dout));

  // R4: width zero follows the input on the tick
  p_follow_w0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && width == '0) |=> (dout == $past(din)));

  // R5: count never runs past the programmed width
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= width));
endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
  parameter int NPINS  = 32,
  parameter int CNT_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out
);
  logic [NPINS-1:0] en_q;
  logic             slow_sel_q;
  logic [CNT_W-1:0] width_q;
  logic             filt_tick;

  dgl_regs #(.NPINS(NPINS), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .sel        (cfg_sel),
    .wdata      (cfg_wdata),
    .rdata      (cfg_rdata),
    .en_q       (en_q),
    .slow_sel_q (slow_sel_q),
    .width_q    (width_q)
  );

  // Clock enable for all filters: every cycle or only on slow ticks
  always_comb begin
    filt_tick = slow_sel_q ? slow_tick : 1'b1;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    dgl_cell #(.CNT_W(CNT_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_q[g]),
      .tick  (filt_tick),
      .din   (pin_in[g]),
      .width (width_q),
      .dout  (pin_out[g])
    );
  end

  // R1: reset leaves outputs low
  p_rst_low_r1: assert property (@(posedge clk)
    !rst_n |-> (pin_out == '0));
endmodule

// File: tb/test_pin_deglitch.sv
`timescale 1ns/1ps
module test_pin_deglitch;
  localparam int NPINS = 32;
  localparam int CNT_W = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        slow_tick;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  pin_deglitch #(.NPINS(NPINS), .CNT_W(CNT_W), .DATA_W(32)) i_pin_deglitch (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pin_in(pin_in), .pin_out(pin_out)
  );

  // Behavioural reference: counts consecutive differing ticks per pin
  logic [31:0] m_en, m_out;
  bit          m_slow;
  int          m_w;
  int          m_run [NPINS];
  bit          m_tk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_out = 0; m_slow = 0; m_w = 0;
      for (int i = 0; i < NPINS; i++) m_run[i] = 0;
    end else begin
      m_tk = m_slow ? slow_tick : 1'b1;
      for (int i = 0; i < NPINS; i++) begin
        if (!m_en[i]) begin
          m_out[i] = 1'b0; m_run[i] = 0;
        end else if (m_tk) begin
          if (pin_in[i] == m_out[i]) m_run[i] = 0;
          else begin
            m_run[i] = m_run[i] + 1;
            if (m_run[i] > m_w) begin m_out[i] = pin_in[i]; m_run[i] = 0; end
          end
        end
      end
      if (cfg_we) begin
        if (cfg_sel == 2'd1 && m_en == 0) m_slow = cfg_wdata[0];
        if (cfg_sel == 2'd2 && m_en == 0) m_w = int'(cfg_wdata[4:0]);
        if (cfg_sel == 2'd0) m_en = cfg_wdata;
      end
    end
  end

  function automatic logic [31:0] exp_rdata();
    case (cfg_sel)
      2'd0: return m_en;
      2'd1: return {31'b0, m_slow};
      2'd2: return 32'(m_w);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rst_n) begin
        chk(phase, "pin_out", pin_out, m_out);
        chk(phase, "cfg_rdata", cfg_rdata, exp_rdata());
      end
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
    cfg_sel = sel;
    #1;
    chk(req, "readback", cfg_rdata, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; slow_tick = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; pin_in = 0;
    repeat (3) @(negedge clk);
    chk("R1", "pin_out in reset", pin_out, 32'h0);
    rst_n = 1'b1;
    phase = "R1";
    cyc(1);
    rd_chk("R1", 2'd0, 32'h0);
    rd_chk("R1", 2'd1, 32'h0);
    rd_chk("R1", 2'd2, 32'h0);
    chk("R1", "pin_out after reset", pin_out, 32'h0);

    // R2: register loads and read-back
    phase = "R2";
    wr(2'd2, 32'hFFFF_FFE3);
    rd_chk("R2", 2'd2, 32'h3);
    wr(2'd1, 32'hFFFF_FFFF);
    rd_chk("R2", 2'd1, 32'h1);
    wr(2'd1, 32'h0);
    wr(2'd3, 32'hDEAD_BEEF);
    rd_chk("R2", 2'd3, 32'h0);
    wr(2'd0, 32'h0000_00A5);
    rd_chk("R2", 2'd0, 32'h0000_00A5);
    wr(2'd0, 32'h0);

    // R4: width 0 follows on the next tick
    phase = "R4";
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h1);
    pin_in[0] = 1'b1;
    cyc(1);
    chk("R4", "pin0 rise w0", {31'b0, pin_out[0]}, 32'h1);
    pin_in[0] = 1'b0;
    cyc(1);
    chk("R4", "pin0 fall w0", {31'b0, pin_out[0]}, 32'h0);
    wr(2'd0, 32'h0);

    // R5 / R6: width 3, pulse of 3 absorbed, hold of 4 passes
    phase = "R5";
    wr(2'd2, 32'h3);
    wr(2'd0, 32'hFFFF_FFFF);
    cyc(2);
    pin_in[1] = 1'b1;
    cyc(3);
    pin_in[1] = 1'b0;
    cyc(2);
    chk("R5", "pin1 3-tick glitch absorbed", {31'b0, pin_out[1]}, 32'h0);
    phase = "R6";
    pin_in[2] = 1'b1;
    cyc(3);
    chk("R6", "pin2 not yet after 3 ticks", {31'b0, pin_out[2]}, 32'h0);
    cyc(1);
    chk("R6", "pin2 passes at 4th tick", {31'b0, pin_out[2]}, 32'h1);
    phase = "R9";
    chk("R9", "other pins untouched", pin_out & ~32'h4, 32'h0);

    // R8: config writes dropped while enabled
    phase = "R8";
    wr(2'd2, 32'h7);
    rd_chk("R8", 2'd2, 32'h3);
    wr(2'd1, 32'h1);
    rd_chk("R8", 2'd1, 32'h0);

    // R3: disabling a high pin forces it low
    phase = "R3";
    wr(2'd0, 32'hFFFF_FFFB);
    cyc(1);
    chk("R3", "pin2 low after disable", {31'b0, pin_out[2]}, 32'h0);
    pin_in = 0;
    wr(2'd0, 32'h0);
    cyc(2);

    // R7: slow tick source
    phase = "R7";
    wr(2'd1, 32'h1);
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h0000_0010);
    pin_in[4] = 1'b1;
    cyc(6);
    chk("R7", "pin4 holds without slow ticks", {31'b0, pin_out[4]}, 32'h0);
    slow_tick = 1'b1; cyc(1); slow_tick = 1'b0;
    cyc(3);
    chk("R7", "pin4 after one slow tick", {31'b0, pin_out[4]}, 32'h0);
    slow_tick = 1'b1; cyc(1); slow_tick = 1'b0;
    cyc(1);
    chk("R7", "pin4 after two slow ticks", {31'b0, pin_out[4]}, 32'h1);
    wr(2'd0, 32'h0);
    pin_in = 0;

    // R9 and mixed: random sparse activity across configurations
    phase = "R9";
    for (int blk = 0; blk < 40; blk++) begin
      wr(2'd0, 32'h0);
      wr(2'd1, {31'b0, 1'($urandom % 2)});
      wr(2'd2, 32'($urandom % 6));
      wr(2'd0, $urandom);
      for (int c = 0; c < 60; c++) begin
        pin_in = pin_in ^ ($urandom & $urandom & $urandom);
        slow_tick = ($urandom % 3) == 0;
        if (c == 30) begin
          wr(2'd2, 32'($urandom));
        end else begin
          cyc(1);
        end
      end
      slow_tick = 1'b0;
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule